// File: doc/BRIEF.md
# SPI Pin Direction and Routing Controller

This block sits between the SPI shift logic and the three shared pads of a serial peripheral port (the master-out data pad, the master-in data pad and the slave-select pad). It decides, cycle by cycle, which pads the port drives, which pad the receive bit is taken from, and what level the slave-select pad carries. It holds the role (master or slave) of the port, because a detected mode fault takes that role away without software involvement.

Three configurations shape the pin use. In normal four-wire operation a master drives the master-out pad and listens on the master-in pad, while a slave does the reverse and only drives while it is selected. In single-wire operation one pad carries data in both directions: the master-out pad for a master, the master-in pad for a slave, with a direction bit choosing between driving and sampling. The slave-select pad can be an automatic output that is low for exactly as long as a transfer is active, or an input used to detect another master pulling it low (a mode fault), which demotes the port to slave and raises a sticky flag.

Top module: `spi_pin_ctrl`

## Requirements
- R1: While `spi_en` is 0, `mosi_oe`, `miso_oe` and `ss_oe` are 0 and `rx_bit` is 0 in the same cycle.
- R2: When `spi_en`, `master`, `fault_en` and `ssout_en` are all 1, `ss_oe` is 1 and `ss_out` is 0 while `xfer_active` is 1 and 1 while `xfer_active` is 0, combinationally.
- R3: When any of `spi_en`, `master`, `fault_en`, `ssout_en` is 0, `ss_oe` is 0 (the slave-select pad is an input).
- R4: With `spi_en`, `master` and `fault_en` at 1 and `ssout_en` at 0, holding `ss_in` low makes `master` 0 and `mode_fault` 1 on the third rising edge after the change (two synchronizer stages, one state register).
- R5: With `ssout_en` at 1 or `fault_en` at 0, a low `ss_in` never sets `mode_fault` nor clears `master`.
- R6: `mode_fault` stays 1 while `spi_en` is 1 and returns to 0 on the first rising edge with `spi_en` at 0.
- R7: Four-wire master (`bidir_en`=0, `master`=1): `mosi_oe`=1, `mosi_out`=`tx_bit`, `miso_oe`=0, `rx_bit`=`miso_in`.
- R8: Four-wire slave: `mosi_oe`=0, `rx_bit`=`mosi_in`, `miso_out`=`tx_bit`, and `miso_oe` is 1 only while the synchronized `ss_in` is low (two edges after `ss_in` falls).
- R9: Single-wire master (`bidir_en`=1, `master`=1): `mosi_oe`=`bidir_oe`, `mosi_out`=`tx_bit`, `rx_bit`=`mosi_in`, `miso_oe`=0.
- R10: Single-wire slave: `miso_oe`=`bidir_oe` while selected (0 when not selected), `miso_out`=`tx_bit`, `rx_bit`=`miso_in`, `mosi_oe`=0.
- R11: A pulse on `mstr_wr` loads `mstr_wd` into `master` at the next rising edge; if a mode fault is detected in the same cycle, `master` becomes 0 and `mode_fault` 1.
- R12: After a mode fault in single-wire master operation the routing becomes single-wire slave: `mosi_oe`=0, `rx_bit`=`miso_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_en | input | 1 | Port enable |
| mstr_wr | input | 1 | Role write strobe |
| mstr_wd | input | 1 | Role value to load (1 = master) |
| fault_en | input | 1 | Mode-fault feature enable |
| ssout_en | input | 1 | Automatic slave-select output enable |
| bidir_en | input | 1 | Single-wire data mode |
| bidir_oe | input | 1 | Shared data pad drives (1) or samples (0) |
| xfer_active | input | 1 | A transfer is in progress |
| tx_bit | input | 1 | Serial bit from the shifter |
| ss_in | input | 1 | Slave-select pad level |
| mosi_in | input | 1 | Master-out pad level |
| miso_in | input | 1 | Master-in pad level |
| mosi_out | output | 1 | Master-out pad drive value |
| mosi_oe | output | 1 | Master-out pad output enable |
| miso_out | output | 1 | Master-in pad drive value |
| miso_oe | output | 1 | Master-in pad output enable |
| ss_out | output | 1 | Slave-select pad drive value |
| ss_oe | output | 1 | Slave-select pad output enable |
| rx_bit | output | 1 | Received serial bit to the shifter |
| master | output | 1 | Current role (1 = master) |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
A software role write and a hardware mode fault can land on the same edge, and the fault must win. The bench provokes this by synchronizing a low slave-select while the fault is masked by the slave-select output enable, then in one cycle clearing that enable and strobing a master write. It judges the result at the following edge: the role must read slave and the fault flag must be set, while a lone write in a quiet cycle must load the written role.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

  typedef enum logic [1:0] {
    WIRE4_SLV = 2'd0,
    WIRE4_MST = 2'd1,
    WIRE1_SLV = 2'd2,
    WIRE1_MST = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic mosi_oe;
    logic miso_oe;
    logic ss_oe;
    logic ss_lvl;
    logic rx_from_mosi;
  } route_t;

  function automatic pin_mode_e pick_mode(input logic bidir, input logic mstr);
    pick_mode = pin_mode_e'({bidir, mstr});
  endfunction

  // Slave-select pad becomes an automatic output
  function automatic logic ss_drive_ok(input logic en, input logic mstr,
                                       input logic fe, input logic soe);
    ss_drive_ok = en & mstr & fe & soe;
  endfunction

  // Mode-fault detection is live
  function automatic logic fault_armed(input logic en, input logic mstr,
                                       input logic fe, input logic soe);
    fault_armed = en & mstr & fe & ~soe;
  endfunction

  function automatic route_t route_pins(input logic en, input pin_mode_e mode,
                                        input logic dir_oe, input logic selected,
                                        input logic ss_drive, input logic xfer);
    route_t r;
    r = '0;
    if (en) begin
      case (mode)
        WIRE4_MST: begin
          r.mosi_oe      = 1'b1;
          r.rx_from_mosi = 1'b0;
        end
        WIRE4_SLV: begin
          r.miso_oe      = selected;
          r.rx_from_mosi = 1'b1;
        end
        WIRE1_MST: begin
          r.mosi_oe      = dir_oe;
          r.rx_from_mosi = 1'b1;
        end
        default: begin
          r.miso_oe      = dir_oe & selected;
          r.rx_from_mosi = 1'b0;
        end
      endcase
      r.ss_oe  = ss_drive;
      r.ss_lvl = ~xfer;
    end else begin
      r.ss_lvl = 1'b1;
    end
    route_pins = r;
  endfunction

endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_raw,
  output logic ss_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= ss_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign ss_sync = chain_q[LAST];
endmodule

// File: rtl/spi_role_ctrl.sv
module spi_role_ctrl
  import spi_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic mstr_wr,
  input  logic mstr_wd,
  input  logic fault_en,
  input  logic ssout_en,
  input  logic ss_sync,
  output logic master_q,
  output logic fault_q,
  output logic fault_event
);
  logic armed;

  assign armed       = fault_armed(spi_en, master_q, fault_en, ssout_en);
  assign fault_event = armed & ~ss_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
    end else if (fault_event) begin
      master_q <= 1'b0;
    end else if (mstr_wr) begin
      master_q <= mstr_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (!spi_en) begin
      fault_q <= 1'b0;
    end else if (fault_event) begin
      fault_q <= 1'b1;
    end
  end

  // R4
  fault_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_event |=> (!master_q && fault_q));

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && spi_en) |=> fault_q);

  // R5
  ssout_masks_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ssout_en || !fault_en) |=> !$rose(fault_q));

  // R11
  role_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_wr && !fault_event) |=> (master_q == $past(mstr_wd)));
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route
  import spi_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic master_q,
  input  logic fault_en,
  input  logic ssout_en,
  input  logic bidir_en,
  input  logic bidir_oe,
  input  logic xfer_active,
  input  logic tx_bit,
  input  logic ss_sync,
  input  logic mosi_in,
  input  logic miso_in,
  output logic mosi_out,
  output logic mosi_oe,
  output logic miso_out,
  output logic miso_oe,
  output logic ss_out,
  output logic ss_oe,
  output logic rx_bit
);
  pin_mode_e mode;
  logic      ss_drive;
  logic      selected;
  route_t    rt;

  assign mode     = pick_mode(bidir_en, master_q);
  assign ss_drive = ss_drive_ok(spi_en, master_q, fault_en, ssout_en);
  assign selected = ~ss_sync;
  assign rt       = route_pins(spi_en, mode, bidir_oe, selected, ss_drive, xfer_active);

  assign mosi_oe  = rt.mosi_oe;
  assign miso_oe  = rt.miso_oe;
  assign ss_oe    = rt.ss_oe;
  assign ss_out   = rt.ss_lvl;
  assign mosi_out = tx_bit;
  assign miso_out = tx_bit;
  assign rx_bit   = spi_en & (rt.rx_from_mosi ? mosi_in : miso_in);

  // R1
  idle_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |-> (!mosi_oe && !miso_oe && !ss_oe && !rx_bit));

  // R2
  ss_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe |-> (ss_out != xfer_active));

  // R3
  ss_only_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe |-> (master_q && fault_en && ssout_en));

  // R9
  one_wire_single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_en |-> !(mosi_oe && miso_oe));

  // R8
  slave_quiet_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && ss_sync) |-> !miso_oe);
endmodule

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic mstr_wr,
  input  logic mstr_wd,
  input  logic fault_en,
  input  logic ssout_en,
  input  logic bidir_en,
  input  logic bidir_oe,
  input  logic xfer_active,
  input  logic tx_bit,
  input  logic ss_in,
  input  logic mosi_in,
  input  logic miso_in,
  output logic mosi_out,
  output logic mosi_oe,
  output logic miso_out,
  output logic miso_oe,
  output logic ss_out,
  output logic ss_oe,
  output logic rx_bit,
  output logic master,
  output logic mode_fault
);
  logic ss_sync;
  logic master_q;
  logic fault_q;
  logic fault_event;

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ss_raw  (ss_in),
    .ss_sync (ss_sync)
  );

  spi_role_ctrl u_role (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_en      (spi_en),
    .mstr_wr     (mstr_wr),
    .mstr_wd     (mstr_wd),
    .fault_en    (fault_en),
    .ssout_en    (ssout_en),
    .ss_sync     (ss_sync),
    .master_q    (master_q),
    .fault_q     (fault_q),
    .fault_event (fault_event)
  );

  spi_pin_route u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_en      (spi_en),
    .master_q    (master_q),
    .fault_en    (fault_en),
    .ssout_en    (ssout_en),
    .bidir_en    (bidir_en),
    .bidir_oe    (bidir_oe),
    .xfer_active (xfer_active),
    .tx_bit      (tx_bit),
    .ss_sync     (ss_sync),
    .mosi_in     (mosi_in),
    .miso_in     (miso_in),
    .mosi_out    (mosi_out),
    .mosi_oe     (mosi_oe),
    .miso_out    (miso_out),
    .miso_oe     (miso_oe),
    .ss_out      (ss_out),
    .ss_oe       (ss_oe),
    .rx_bit      (rx_bit)
  );

  assign master     = master_q;
  assign mode_fault = fault_q;

  // R12
  demoted_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_event && bidir_en) |=> (!mosi_oe || !bidir_en));
endmodule

// File: tb/spi_pin_ctrl_bench.sv
module spi_pin_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 0, mstr_wr = 0, mstr_wd = 0, fault_en = 0, ssout_en = 0;
  logic bidir_en = 0, bidir_oe = 0, xfer_active = 0, tx_bit = 0;
  logic ss_in = 1, mosi_in = 0, miso_in = 0;
  logic mosi_out, mosi_oe, miso_out, miso_oe, ss_out, ss_oe, rx_bit, master, mode_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_pin_ctrl u_spi_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .mstr_wr(mstr_wr), .mstr_wd(mstr_wd),
    .fault_en(fault_en), .ssout_en(ssout_en), .bidir_en(bidir_en), .bidir_oe(bidir_oe),
    .xfer_active(xfer_active), .tx_bit(tx_bit), .ss_in(ss_in), .mosi_in(mosi_in),
    .miso_in(miso_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_out(miso_out),
    .miso_oe(miso_oe), .ss_out(ss_out), .ss_oe(ss_oe), .rx_bit(rx_bit),
    .master(master), .mode_fault(mode_fault)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic set_role(input logic v);
    @(negedge clk); mstr_wr = 1; mstr_wd = v;
    @(negedge clk); mstr_wr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    spi_en = 0; fault_en = 0; ssout_en = 0; bidir_en = 0; bidir_oe = 0;
    xfer_active = 0; ss_in = 1; mstr_wr = 0;
    cyc(4);
  endtask

  task automatic t_reset();
    settle();
    chk("R1", "reset master", master, 1'b0);
    chk("R1", "reset fault", mode_fault, 1'b0);
    chk("R1", "reset mosi_oe", mosi_oe, 1'b0);
    chk("R1", "reset miso_oe", miso_oe, 1'b0);
    chk("R1", "reset ss_oe", ss_oe, 1'b0);
  endtask

  task automatic t_disabled();
    set_role(1);
    spi_en = 0; fault_en = 1; ssout_en = 1; miso_in = 1; mosi_in = 1;
    settle();
    chk("R1", "off mosi_oe", mosi_oe, 0);
    chk("R1", "off ss_oe", ss_oe, 0);
    chk("R1", "off rx_bit", rx_bit, 0);
  endtask

  task automatic t_ss_output();
    spi_en = 1; fault_en = 1; ssout_en = 1; xfer_active = 0;
    settle();
    chk("R2", "ss_oe idle", ss_oe, 1);
    chk("R2", "ss high idle", ss_out, 1);
    xfer_active = 1; settle();
    chk("R2", "ss low in transfer", ss_out, 0);
    ss_in = 0; cyc(5);
    chk("R5", "no fault with ss output", mode_fault, 0);
    chk("R5", "master kept with ss output", master, 1);
    xfer_active = 0; ss_in = 1; settle();
    chk("R2", "ss high after transfer", ss_out, 1);
    ssout_en = 0; settle();
    chk("R3", "ss input when output off", ss_oe, 0);
    fault_en = 0; ssout_en = 1; settle();
    chk("R3", "ss input without fault_en", ss_oe, 0);
    ss_in = 0; cyc(5);
    chk("R5", "no fault with fault_en 0", mode_fault, 0);
    ss_in = 1; cyc(3);
  endtask

  task automatic t_four_wire_master();
    spi_en = 1; bidir_en = 0; fault_en = 0; ssout_en = 0;
    tx_bit = 1; miso_in = 0; mosi_in = 1; settle();
    chk("R7", "mosi_oe", mosi_oe, 1);
    chk("R7", "mosi_out", mosi_out, 1);
    chk("R7", "miso_oe", miso_oe, 0);
    chk("R7", "rx from miso", rx_bit, 0);
    miso_in = 1; tx_bit = 0; settle();
    chk("R7", "rx from miso hi", rx_bit, 1);
    chk("R7", "mosi_out lo", mosi_out, 0);
  endtask

  task automatic t_four_wire_slave();
    set_role(0);
    tx_bit = 1; mosi_in = 1; miso_in = 0; ss_in = 1; settle();
    chk("R8", "mosi_oe slave", mosi_oe, 0);
    chk("R8", "miso_oe unselected", miso_oe, 0);
    chk("R8", "rx from mosi", rx_bit, 1);
    ss_in = 0; cyc(2); settle();
    chk("R8", "miso_oe selected", miso_oe, 1);
    chk("R8", "miso_out", miso_out, 1);
    ss_in = 1; cyc(3);
    chk("R8", "miso_oe released", miso_oe, 0);
  endtask

  task automatic t_bidir_master();
    set_role(1);
    bidir_en = 1; bidir_oe = 1; tx_bit = 1; mosi_in = 0; miso_in = 1; settle();
    chk("R9", "mosi_oe drive", mosi_oe, 1);
    chk("R9", "miso_oe", miso_oe, 0);
    chk("R9", "mosi_out", mosi_out, 1);
    bidir_oe = 0; mosi_in = 1; miso_in = 0; settle();
    chk("R9", "mosi_oe sample", mosi_oe, 0);
    chk("R9", "rx from mosi", rx_bit, 1);
  endtask

  task automatic t_bidir_slave();
    set_role(0);
    bidir_en = 1; bidir_oe = 1; ss_in = 0; cyc(3);
    mosi_in = 0; miso_in = 1; settle();
    chk("R10", "miso_oe selected", miso_oe, 1);
    chk("R10", "mosi_oe", mosi_oe, 0);
    chk("R10", "rx from miso", rx_bit, 1);
    ss_in = 1; cyc(3);
    chk("R10", "miso_oe unselected", miso_oe, 0);
    bidir_oe = 0; ss_in = 0; cyc(3);
    chk("R10", "miso_oe sampling", miso_oe, 0);
    ss_in = 1; cyc(3);
  endtask

  task automatic t_fault_bidir();
    clear_all();
    spi_en = 1; bidir_en = 1; bidir_oe = 1; fault_en = 1; ssout_en = 0;
    set_role(1);
    ss_in = 0;
    cyc(2);
    chk("R4", "master before 3rd edge", master, 1);
    cyc(1);
    chk("R4", "master cleared", master, 0);
    chk("R4", "fault set", mode_fault, 1);
    miso_in = 1; mosi_in = 0; settle();
    chk("R12", "mosi released", mosi_oe, 0);
    chk("R12", "miso data pin", miso_oe, 1);
    chk("R12", "rx from miso", rx_bit, 1);
    ss_in = 1; cyc(4);
    chk("R6", "fault sticky", mode_fault, 1);
    spi_en = 0; cyc(1);
    chk("R6", "fault cleared", mode_fault, 0);
  endtask

  task automatic t_collision();
    clear_all();
    spi_en = 1; fault_en = 1; ssout_en = 1;
    set_role(1);
    ss_in = 0; cyc(3);
    chk("R11", "masked, still master", master, 1);
    ssout_en = 0; mstr_wr = 1; mstr_wd = 1;
    @(negedge clk); mstr_wr = 0; ssout_en = 1;
    chk("R11", "fault wins over write", master, 0);
    chk("R11", "fault flag on collision", mode_fault, 1);
    ss_in = 1; spi_en = 0; cyc(1); spi_en = 1;
    set_role(1);
    chk("R11", "plain write loads", master, 1);
    set_role(0);
    chk("R11", "plain write clears", master, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_disabled();
    t_ss_output();
    t_four_wire_master();
    t_four_wire_slave();
    t_bidir_master();
    t_bidir_slave();
    t_fault_bidir();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule